// File: doc/BRIEF.md
# Hardware Store Pin Controller

This block drives the shared active-low store request pin of a battery-free nonvolatile SRAM. An external agent pulls the pin low to ask for the SRAM contents to be saved into the nonvolatile cells. The controller samples the pin through a two-stage synchroniser and accepts the request only if the pin stays low for a minimum number of cycles. It then raises `access_inhibit` and lets any SRAM cycle already in progress finish. After that it copies the array into the nonvolatile cells, but only if the array has been written since the last nonvolatile operation.

While the copy runs, the controller pulls the same pin low itself. Other agents on the open-drain line can therefore see that the memory is busy. After the copy the pin is released, and SRAM access stays blocked until the pin reads high again. If a copy took place, a further recovery interval follows before access is allowed. When no write has happened since the last store or recall, the request is still honoured as a standby-until-high phase, but no copy is made and no recovery interval is added.

All durations are parameters counted in clock cycles, so that an integration can derive them from its clock frequency and a bench can scale them down. The nonvolatile cell array and the address decoding live elsewhere. `nv_copy_en` tells the array when to copy, and `access_inhibit` gates the bus.

Top module: `nvstore_pin_ctrl`

## Requirements
- R1: After reset, `access_inhibit`, `hsb_pull_low` and `nv_copy_en` are all low, and the array is treated as clean.
- R2: A request is accepted only when the synchronised pin level has been low for at least MIN_LOW_CYC consecutive clock cycles. A shorter low pulse causes no change on any output.
- R3: An accepted request raises `access_inhibit` and starts a drain phase. The drain phase ends after one cycle if `sram_busy` is low, ends when `sram_busy` falls, and lasts at most DRAIN_MAX_CYC cycles while `sram_busy` stays high.
- R4: When the array is clean at the end of the drain phase, no copy is made: `hsb_pull_low` and `nv_copy_en` stay low.
- R5: When the array is dirty at the end of the drain phase, `hsb_pull_low` and `nv_copy_en` are both high for exactly COPY_CYC consecutive cycles.
- R6: The array becomes dirty on any `sram_write` pulse taken while idle or during the drain phase, including its last cycle. Writes presented during the copy, hold or recovery phases are ignored.
- R7: The dirty state clears when a copy completes or when `recall_done` pulses. A write in the same cycle as `recall_done` leaves the array dirty.
- R8: After a copy, `access_inhibit` stays high while the synchronised pin reads low. It falls exactly RECOVER_CYC+3 rising clock edges after the pin is released: two synchroniser stages, one cycle to detect the level, and then the recovery count.
- R9: After a request that made no copy, `access_inhibit` falls on the third rising edge after the pin is released, with no recovery interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsb_pin_in | input | 1 | Level read back from the open-drain store pin (asynchronous) |
| sram_busy | input | 1 | High while an SRAM access cycle is in progress |
| sram_write | input | 1 | One-cycle pulse per completed SRAM write |
| recall_done | input | 1 | One-cycle pulse when a recall from the nonvolatile cells finishes |
| hsb_pull_low | output | 1 | Enables the open-drain pull-down on the store pin (busy indication) |
| nv_copy_en | output | 1 | High while the nonvolatile array copies the SRAM contents |
| access_inhibit | output | 1 | Blocks SRAM reads and writes during drain, copy, hold and recovery |

## Verification
The assertions assume that `sram_write` and `recall_done` are single-cycle pulses. They also assume that the pin level seen by the block combines the external pull-down with the block's own `hsb_pull_low`, as an open-drain line does. The bench models the line exactly that way. It drives writes and recalls only while the block is idle, except in the directed cases that deliberately place a write in the drain or post-copy phase. Low pulse lengths are drawn at random on both sides of the minimum width, and `sram_busy` is held either high or low for a whole request.

// File: rtl/nvstore_pkg.sv
// Package: shared phase encoding and helpers for the store pin controller.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package nvstore_pkg;

    typedef enum logic [2:0] {
        PH_IDLE         = 3'd0,
        PH_DRAIN        = 3'd1,
        PH_COPY         = 3'd2,
        PH_HOLD_COPIED  = 3'd3,
        PH_HOLD_SKIPPED = 3'd4,
        PH_RECOVER      = 3'd5
    } phase_t;

    // Largest of three cycle counts, used to size the shared timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/nvs_pin_sync.sv
// Module: nvs_pin_sync
// Brings the asynchronous store pin into the clock domain with two flops,
// then qualifies a low level by its width. The request pulse is one cycle
// long and fires once per low period, on the cycle in which the pin has been
// low for MIN_LOW_CYC consecutive cycles.
// Assumes: MIN_LOW_CYC >= 1; the pin idles high.
module nvs_pin_sync #(
    parameter int MIN_LOW_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_level,
    output logic req_pulse
);
    localparam int LW = $clog2(MIN_LOW_CYC + 1);

    logic          meta_q;
    logic          sync_q;
    logic [LW-1:0] low_run_q;

    // Two-stage synchroniser for the pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
        end
    end

    // Count consecutive low cycles, saturating once the minimum is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (sync_q) begin
            low_run_q <= '0;
        end else if (low_run_q != LW'(MIN_LOW_CYC)) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    assign pin_level = sync_q;
    assign req_pulse = !sync_q && (low_run_q == LW'(MIN_LOW_CYC - 1));

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |=> !req_pulse);

endmodule

// File: rtl/nvs_dirty_tracker.sv
// Module: nvs_dirty_tracker
// Remembers whether the SRAM holds data newer than the nonvolatile copy.
// A qualified write sets the flag; a finished copy or recall clears it. A
// write in the same cycle as a clear wins, since it lands after the recall.
// Assumes: mark, clear_copy and clear_recall are single-cycle pulses.
module nvs_dirty_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    input  logic clear_copy,
    input  logic clear_recall,
    output logic dirty
);
    logic dirty_q;

    // Set or clear the flag; a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else begin
            dirty_q <= (dirty_q && !(clear_copy || clear_recall)) || mark;
        end
    end

    assign dirty = dirty_q;

    // R6
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> dirty);

endmodule

// File: rtl/nvs_phase_timer.sv
// Module: nvs_phase_timer
// Down-counter shared by the timed phases. Loading N-1 makes the phase last
// N cycles: expired is high in the last one.
// Assumes: the controller loads it on every entry into a timed phase.
module nvs_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvstore_pin_ctrl.sv
// Module: nvstore_pin_ctrl (top)
// Sequences a hardware store request on an open-drain, active-low pin:
// qualify the request, drain the SRAM cycle in flight, copy to the
// nonvolatile cells only if the array is dirty (pulling the pin low as a busy
// flag), hold off access until the pin reads high, then recover if a copy was
// made. All durations are cycle counts.
// Assumes: hsb_pin_in is the wired level of the line, including this block's
// own pull-down; sram_write and recall_done are single-cycle pulses.
module nvstore_pin_ctrl #(
    parameter int MIN_LOW_CYC   = 4,
    parameter int DRAIN_MAX_CYC = 175,
    parameter int COPY_CYC      = 2500000,
    parameter int RECOVER_CYC   = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsb_pin_in,
    input  logic sram_busy,
    input  logic sram_write,
    input  logic recall_done,
    output logic hsb_pull_low,
    output logic nv_copy_en,
    output logic access_inhibit
);
    import nvstore_pkg::*;

    localparam int MAX_CYC = max3(DRAIN_MAX_CYC, COPY_CYC, RECOVER_CYC);
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    phase_t             ph_q;
    phase_t             ph_d;
    logic               pin_level;
    logic               req_pulse;
    logic               dirty_q;
    logic               write_mark;
    logic               copy_finish;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_exp;

    nvs_pin_sync #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (hsb_pin_in),
        .pin_level(pin_level),
        .req_pulse(req_pulse)
    );

    // Writes count only while idle or while the in-flight cycle drains.
    assign write_mark = sram_write && ((ph_q == PH_IDLE) || (ph_q == PH_DRAIN));

    nvs_dirty_tracker u_dirty (
        .clk         (clk),
        .rst_n       (rst_n),
        .mark        (write_mark),
        .clear_copy  (copy_finish),
        .clear_recall(recall_done),
        .dirty       (dirty_q)
    );

    nvs_phase_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp)
    );

    // Next-phase decision and timer loading.
    always_comb begin
        ph_d        = ph_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        copy_finish = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req_pulse) begin
                    ph_d     = PH_DRAIN;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(DRAIN_MAX_CYC - 1);
                end
            end
            PH_DRAIN: begin
                if (!sram_busy || tmr_exp) begin
                    if (dirty_q || sram_write) begin
                        ph_d     = PH_COPY;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(COPY_CYC - 1);
                    end else begin
                        ph_d = PH_HOLD_SKIPPED;
                    end
                end
            end
            PH_COPY: begin
                if (tmr_exp) begin
                    ph_d        = PH_HOLD_COPIED;
                    copy_finish = 1'b1;
                end
            end
            PH_HOLD_COPIED: begin
                if (pin_level) begin
                    ph_d     = PH_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RECOVER_CYC - 1);
                end
            end
            PH_HOLD_SKIPPED: begin
                if (pin_level) begin
                    ph_d = PH_IDLE;
                end
            end
            PH_RECOVER: begin
                if (tmr_exp) begin
                    ph_d = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign access_inhibit = (ph_q != PH_IDLE);
    assign hsb_pull_low   = (ph_q == PH_COPY);
    assign nv_copy_en     = (ph_q == PH_COPY);

    // R3
    inhibit_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_inhibit) |-> $past(req_pulse));

    // R4
    copy_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_copy_en) |-> $past(dirty_q || sram_write));

    // R7
    dirty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsb_pull_low) |-> !dirty_q);

    // R8
    hold_until_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_HOLD_COPIED && !pin_level) |=> access_inhibit);

endmodule

// File: tb/test_nvstore_pin_ctrl.sv
module test_nvstore_pin_ctrl;
    localparam int MIN_L = 3;
    localparam int DRN   = 6;
    localparam int CPY   = 20;
    localparam int REC   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_low = 1'b0;
    logic sram_busy = 1'b0;
    logic sram_write = 1'b0;
    logic recall_done = 1'b0;
    logic hsb_pull_low, nv_copy_en, access_inhibit;
    logic hsb_pin;

    int  checks = 0;
    int  fails = 0;
    bit  model_dirty = 1'b0;
    bit  finished = 1'b0;

    // Open-drain line: low if anyone pulls.
    assign hsb_pin = ~(ext_low | hsb_pull_low);

    always #2 clk = ~clk;

    nvstore_pin_ctrl #(
        .MIN_LOW_CYC(MIN_L), .DRAIN_MAX_CYC(DRN),
        .COPY_CYC(CPY), .RECOVER_CYC(REC)
    ) i_nvstore_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .hsb_pin_in(hsb_pin),
        .sram_busy(sram_busy), .sram_write(sram_write),
        .recall_done(recall_done), .hsb_pull_low(hsb_pull_low),
        .nv_copy_en(nv_copy_en), .access_inhibit(access_inhibit)
    );

    task automatic check_eq(input string req, input string what,
                            input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_drain(input bit busy);
        return busy ? DRN : 1;
    endfunction

    function automatic int exp_post(input bit long_hold);
        return long_hold ? REC + 2 : REC + 3;
    endfunction

    task automatic write_idle();
        @(negedge clk); sram_write = 1'b1;
        @(negedge clk); sram_write = 1'b0;
        model_dirty = 1'b1;
    endtask

    task automatic recall(input bit with_write);
        @(negedge clk); recall_done = 1'b1; sram_write = with_write;
        @(negedge clk); recall_done = 1'b0; sram_write = 1'b0;
        model_dirty = with_write;
    endtask

    // One request: pin low for L cycles; wr_at 1 = write in drain, 2 = write after copy.
    task automatic hsb_cycle(input int L, input bit busy, input int wr_at);
        bit accepted, expst, seen_inh, seen_pull, long_hold, first_post, wr_done;
        int k, pull_n, pre_n, post_n, free_n, mism;
        accepted = (L >= MIN_L);
        expst = accepted && (model_dirty || wr_at == 1);
        seen_inh = 0; seen_pull = 0; long_hold = 0; first_post = 1; wr_done = 0;
        pull_n = 0; pre_n = 0; post_n = 0; free_n = 0; mism = 0; k = 0;
        @(negedge clk); sram_busy = busy; ext_low = 1'b1;
        forever begin
            @(negedge clk); k++;
            sram_write = 1'b0;
            if (nv_copy_en != hsb_pull_low) mism++;
            if (access_inhibit) seen_inh = 1;
            if (access_inhibit && !ext_low) free_n++;
            if (hsb_pull_low) begin
                seen_pull = 1; pull_n++;
            end else if (access_inhibit && !seen_pull) begin
                pre_n++;
                if (wr_at == 1 && !wr_done) begin sram_write = 1'b1; wr_done = 1; end
            end else if (access_inhibit && seen_pull) begin
                if (first_post) begin long_hold = ext_low; first_post = 0; end
                if (!ext_low) post_n++;
                if (wr_at == 2 && !wr_done) begin sram_write = 1'b1; wr_done = 1; end
            end
            if (k == L) ext_low = 1'b0;
            if (seen_inh && !access_inhibit && k > L) break;
            if (!seen_inh && k > L + 8) break;
            if (k > 4000) break;
        end
        sram_busy = 1'b0; ext_low = 1'b0; sram_write = 1'b0;
        repeat (4) @(negedge clk);
        if (!accepted) begin
            check_eq("R2", "short pulse inhibit seen", int'(seen_inh), 0);
        end else begin
            check_eq("R2", "accepted pulse inhibit seen", int'(seen_inh), 1);
            if (expst) begin
                check_eq("R5", "copy cycles", pull_n, CPY);
                check_eq("R5", "copy_en/pull mismatch", mism, 0);
                check_eq("R3", "drain cycles", pre_n, exp_drain(busy));
                check_eq("R8", "post-copy inhibit cycles", post_n, exp_post(long_hold));
            end else begin
                check_eq("R4", "copy cycles on clean array", pull_n, 0);
                if (!busy) check_eq("R9", "inhibit cycles after release", free_n, 2);
            end
        end
        check_eq("R8", "inhibit released at end", int'(access_inhibit), 0);
        if (expst) model_dirty = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "access_inhibit", int'(access_inhibit), 0);
        check_eq("R1", "hsb_pull_low", int'(hsb_pull_low), 0);
        check_eq("R1", "nv_copy_en", int'(nv_copy_en), 0);
        // R1/R4: clean after reset, no copy
        hsb_cycle(MIN_L, 1'b0, 0);
        // R2: too-short pulse ignored, dirty kept
        write_idle();
        hsb_cycle(MIN_L - 1, 1'b0, 0);
        // R5: minimal pulse performs copy
        hsb_cycle(MIN_L, 1'b0, 0);
        // R3: drain waits for busy up to its limit
        write_idle();
        hsb_cycle(MIN_L, 1'b1, 0);
        // R8: pin held long after copy
        write_idle();
        hsb_cycle(60, 1'b0, 0);
        // R6: write landing in drain phase is counted
        hsb_cycle(MIN_L, 1'b1, 1);
        hsb_cycle(MIN_L, 1'b0, 1);
        // R6: write after copy ignored
        write_idle();
        hsb_cycle(MIN_L, 1'b0, 2);
        hsb_cycle(MIN_L, 1'b0, 0);
        // R7: recall clears, write with recall keeps dirty
        write_idle();
        recall(1'b0);
        hsb_cycle(MIN_L + 1, 1'b0, 0);
        recall(1'b1);
        hsb_cycle(MIN_L + 1, 1'b0, 0);
        // Random mix
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 3 == 0) write_idle();
            if ($urandom % 4 == 0) recall(1'b0);
            if ($urandom % 3 == 0) write_idle();
            hsb_cycle(1 + int'($urandom % (MIN_L + 5)), 1'($urandom % 2), 0);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule